// File: doc/BRIEF.md
# Dual Wiper Register Command Controller

This block sits behind a serial front-end that has already assembled host traffic into bytes and single clock pulses. It keeps the digital state of two 64-position wipers. Each wiper has a live 6-bit position register and four 6-bit stored presets. A frame opens when the chip select goes low. Its first byte names the device and must match the two address pins. The second byte carries the opcode, the preset index and the wiper index. A few opcodes take a third byte, which holds data.

Live positions change inside the frame. Changes to the stored presets are held as pending and take effect only when chip select rises, and then only if the frame was complete. Each such save starts a busy window of fixed length, and write commands to the presets are refused while that window is open. An open-ended stepping mode moves one wiper by one tap for each pulse until the frame closes. Each wiper position is also given out as a one-hot tap select.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After reset both live positions and all eight presets are 0, `wip_o` is 0, `rd_valid_o` is 0 and each tap select has only bit 0 set.
- R2: The first byte of a frame must be 0101 in bits 7:4, 00 in bits 3:2, and `addr_i` in bits 1:0. Any other first byte makes the rest of the frame have no effect.
- R3: Instruction byte fields are opcode in bits 7:4, preset index in bits 3:2, a reserved bit 1 that must be 0, and wiper index in bit 0. The opcodes are: 0x1 save both live positions to presets; 0x2 step; 0x5 read status; 0x8 load both from presets; 0x9 read position; 0xA write position; 0xB read preset; 0xC write preset; 0xD load from preset; 0xE save to preset. A set reserved bit or any other opcode makes the frame have no effect.
- R4: Each tap select output has exactly one bit set, at the index equal to that wiper's live position.
- R5: Opcodes 0xD (one wiper) and 0x8 (both wipers) copy the indexed preset into the live position at the instruction byte.
- R6: Opcode 0xA loads bits 5:0 of the third byte into the selected live position and ignores bits 7:6.
- R7: Opcodes 0x9 and 0xB raise `rd_valid_o` for one cycle, in the cycle after the instruction byte, with `rd_data_o` = {2'b00, value}.
- R8: Opcode 0x5 returns `rd_data_o` = {7'b0, wip} with the same timing as R7.
- R9: Opcodes 0xE and 0x1 (two-byte) and 0xC (three-byte, data in bits 5:0) change presets only when chip select rises after the whole frame has arrived. That edge makes `wip_o` high for exactly WRITE_CYCLES cycles. A frame cut short changes nothing and leaves `wip_o` low.
- R10: If `wp_ni` is low when chip select rises, the pending preset change is dropped and `wip_o` stays low.
- R11: A preset write command (0xE, 0x1, 0xC) whose instruction byte arrives while `wip_o` is high has no effect.
- R12: After opcode 0x2, each `step_valid_i` pulse moves the selected position up one tap if `step_up_i` is 1, or down one tap if it is 0. The position saturates at 63 and at 0. Bytes have no effect in this mode, and steps have no effect outside it.
- R13: Bytes received while chip select is high, or after a frame has completed, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; rising edge ends the frame |
| byte_valid_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| step_valid_i | input | 1 | One serial clock pulse while in step mode |
| step_up_i | input | 1 | Data line level for that pulse: 1 up, 0 down |
| wp_ni | input | 1 | Write protect, active low |
| addr_i | input | 2 | Device address pins |
| rd_valid_o | output | 1 | Read data is valid |
| rd_data_o | output | 8 | Byte to shift back to the host |
| wip_o | output | 1 | Preset write in progress |
| wcr0_o | output | 6 | Live position of wiper 0 |
| wcr1_o | output | 6 | Live position of wiper 1 |
| sel0_o | output | 64 | One-hot tap select of wiper 0 |
| sel1_o | output | 64 | One-hot tap select of wiper 1 |

## Verification
A table of frames builds up state step by step. It writes both positions, saves and writes presets, and loads them back in both the single and global forms. Reading the results back distinguishes a wrong wiper index from a wrong preset index. Bad identities, a set reserved bit and an unused opcode are placed between valid frames, so a frame that wrongly takes effect shows up as a changed position. Directed frames then measure the busy window cycle by cycle. They read status inside that window, try a save inside it, drop the write-protect pin, cut a frame short, step both wipers into both saturation limits, and send stray bytes outside a frame and after a frame has completed.

// File: rtl/wiper_ctrl_pkg.sv
package wiper_ctrl_pkg;
  localparam int NUM_WIPERS  = 2;
  localparam int NUM_DR      = 4;
  localparam int DR_IDX_BITS = $clog2(NUM_DR);
  localparam int BYTE_W      = 8;
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [3:0] {
    OPC_NOP    = 4'h0,
    OPC_GSAVE  = 4'h1,
    OPC_STEP   = 4'h2,
    OPC_STATUS = 4'h5,
    OPC_GLOAD  = 4'h8,
    OPC_RD_WCR = 4'h9,
    OPC_WR_WCR = 4'hA,
    OPC_RD_DR  = 4'hB,
    OPC_WR_DR  = 4'hC,
    OPC_LOAD   = 4'hD,
    OPC_SAVE   = 4'hE
  } opcode_e;

  typedef enum logic [1:0] {
    WOP_NONE,
    WOP_LOAD,
    WOP_SET,
    WOP_STEP
  } wcr_op_e;

  typedef enum logic [2:0] {
    ST_ID,
    ST_INSTR,
    ST_DATA,
    ST_STEP,
    ST_DONE,
    ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/wcmd_tapsel.sv
module wcmd_tapsel #(
  parameter int TAP_BITS = 6,
  localparam int TAPS    = 1 << TAP_BITS
) (
  input  logic [TAP_BITS-1:0] code_i,
  output logic [TAPS-1:0]     sel_o
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign sel_o[i] = (code_i == TAP_BITS'(i));
  end
endmodule

// File: rtl/wcmd_wtimer.sv
module wcmd_wtimer #(
  parameter int WRITE_CYCLES = 1000,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(WRITE_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_start_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_idle_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/wcmd_regbank.sv
module wcmd_regbank
  import wiper_ctrl_pkg::*;
#(
  parameter int TAP_BITS = 6
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  wcr_op_e                              wcr_op_i,
  input  logic [NUM_WIPERS-1:0]                wcr_mask_i,
  input  logic [DR_IDX_BITS-1:0]               wcr_idx_i,
  input  logic [TAP_BITS-1:0]                  wcr_val_i,
  input  logic                                 step_up_i,
  input  logic                                 dr_we_i,
  input  logic [NUM_WIPERS-1:0]                dr_mask_i,
  input  logic [DR_IDX_BITS-1:0]               dr_idx_i,
  input  logic                                 dr_from_wcr_i,
  input  logic [TAP_BITS-1:0]                  dr_val_i,
  input  logic                                 rd_dr_i,
  input  logic                                 rd_wiper_i,
  input  logic [DR_IDX_BITS-1:0]               rd_idx_i,
  output logic [TAP_BITS-1:0]                  rd_val_o,
  output logic [NUM_WIPERS-1:0][TAP_BITS-1:0]  wcr_o
);
  localparam logic [TAP_BITS-1:0] TAP_MAX = '1;

  logic [NUM_WIPERS-1:0][TAP_BITS-1:0]              wcr_q;
  logic [NUM_WIPERS-1:0][NUM_DR-1:0][TAP_BITS-1:0]  dr_q;

  function automatic logic [TAP_BITS-1:0] step_tap(input logic [TAP_BITS-1:0] cur,
                                                   input logic up);
    if (up) return (cur == TAP_MAX) ? cur : cur + 1'b1;
    else    return (cur == '0)      ? cur : cur - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcr_q <= '0;
      dr_q  <= '0;
    end else begin
      for (int w = 0; w < NUM_WIPERS; w++) begin
        if (wcr_mask_i[w]) begin
          case (wcr_op_i)
            WOP_LOAD: wcr_q[w] <= dr_q[w][wcr_idx_i];
            WOP_SET:  wcr_q[w] <= wcr_val_i;
            WOP_STEP: wcr_q[w] <= step_tap(wcr_q[w], step_up_i);
            default:  ;
          endcase
        end
        if (dr_we_i && dr_mask_i[w])
          dr_q[w][dr_idx_i] <= dr_from_wcr_i ? wcr_q[w] : dr_val_i;
      end
    end
  end

  assign rd_val_o = rd_dr_i ? dr_q[rd_wiper_i][rd_idx_i] : wcr_q[rd_wiper_i];
  assign wcr_o    = wcr_q;

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_chk
    p_inc_sat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wcr_op_i == WOP_STEP && wcr_mask_i[w] && step_up_i && wcr_q[w] == TAP_MAX)
      |=> wcr_q[w] == TAP_MAX);
    p_dec_sat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wcr_op_i == WOP_STEP && wcr_mask_i[w] && !step_up_i && wcr_q[w] == '0)
      |=> wcr_q[w] == '0);
    p_dr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dr_we_i && dr_mask_i[w]) |=> $stable(dr_q[w]));
    p_wcr_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wcr_mask_i[w] || wcr_op_i == WOP_NONE) |=> $stable(wcr_q[w]));
  end
endmodule

// File: rtl/wcmd_decoder.sv
module wcmd_decoder
  import wiper_ctrl_pkg::*;
#(
  parameter int TAP_BITS = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    byte_valid_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic                    step_valid_i,
  input  logic                    step_up_i,
  input  logic                    wp_ni,
  input  logic [1:0]              addr_i,
  input  logic                    wip_i,
  input  logic [TAP_BITS-1:0]     rd_val_i,
  output logic                    rd_dr_o,
  output logic                    rd_wiper_o,
  output logic [DR_IDX_BITS-1:0]  rd_idx_o,
  output logic                    rd_valid_o,
  output logic [BYTE_W-1:0]       rd_data_o,
  output wcr_op_e                 wcr_op_o,
  output logic [NUM_WIPERS-1:0]   wcr_mask_o,
  output logic [DR_IDX_BITS-1:0]  wcr_idx_o,
  output logic [TAP_BITS-1:0]     wcr_val_o,
  output logic                    step_up_o,
  output logic                    dr_we_o,
  output logic [NUM_WIPERS-1:0]   dr_mask_o,
  output logic [DR_IDX_BITS-1:0]  dr_idx_o,
  output logic                    dr_from_wcr_o,
  output logic [TAP_BITS-1:0]     dr_val_o
);
  frame_st_e                st_q, st_d;
  opcode_e                  opc_q;
  logic                     wsel_q;
  logic [DR_IDX_BITS-1:0]   ridx_q;
  logic                     cs_q;
  logic                     rd_valid_q;
  logic [BYTE_W-1:0]        rd_data_q;
  logic                     pend_q;
  logic [NUM_WIPERS-1:0]    pend_mask_q;
  logic [DR_IDX_BITS-1:0]   pend_idx_q;
  logic                     pend_from_wcr_q;
  logic [TAP_BITS-1:0]      pend_val_q;

  opcode_e                  opc_in;
  logic                     byte_ok, id_ok, rd_go;
  logic                     pend_set, pend_from_wcr_d;
  logic [NUM_WIPERS-1:0]    pend_mask_d, one_in, one_q;
  logic [DR_IDX_BITS-1:0]   pend_idx_d;

  assign opc_in  = opcode_e'(byte_i[7:4]);
  assign byte_ok = !cs_ni && byte_valid_i;
  assign id_ok   = (byte_i[7:4] == DEV_TYPE) && (byte_i[3:2] == 2'b00) && (byte_i[1:0] == addr_i);
  assign one_in  = NUM_WIPERS'(1) << byte_i[0];
  assign one_q   = NUM_WIPERS'(1) << wsel_q;

  always_comb begin
    st_d            = st_q;
    wcr_op_o        = WOP_NONE;
    wcr_mask_o      = '0;
    wcr_idx_o       = byte_i[3:2];
    wcr_val_o       = byte_i[TAP_BITS-1:0];
    rd_go           = 1'b0;
    pend_set        = 1'b0;
    pend_mask_d     = one_in;
    pend_idx_d      = byte_i[3:2];
    pend_from_wcr_d = 1'b0;
    if (byte_ok) begin
      case (st_q)
        ST_ID:    st_d = id_ok ? ST_INSTR : ST_SKIP;
        ST_INSTR: begin
          st_d = ST_DONE;
          if (byte_i[1]) st_d = ST_SKIP;
          else begin
            case (opc_in)
              OPC_LOAD:  begin wcr_op_o = WOP_LOAD; wcr_mask_o = one_in; end
              OPC_GLOAD: begin wcr_op_o = WOP_LOAD; wcr_mask_o = '1;     end
              OPC_SAVE, OPC_GSAVE: begin
                if (wip_i) st_d = ST_SKIP;
                else begin
                  pend_set        = 1'b1;
                  pend_from_wcr_d = 1'b1;
                  if (opc_in == OPC_GSAVE) pend_mask_d = '1;
                end
              end
              OPC_RD_WCR, OPC_RD_DR, OPC_STATUS: rd_go = 1'b1;
              OPC_WR_WCR: st_d = ST_DATA;
              OPC_WR_DR:  st_d = wip_i ? ST_SKIP : ST_DATA;
              OPC_STEP:   st_d = ST_STEP;
              default:    st_d = ST_SKIP;
            endcase
          end
        end
        ST_DATA: begin
          st_d = ST_DONE;
          if (opc_q == OPC_WR_WCR) begin
            wcr_op_o   = WOP_SET;
            wcr_mask_o = one_q;
          end else begin
            pend_set    = 1'b1;
            pend_mask_d = one_q;
            pend_idx_d  = ridx_q;
          end
        end
        default: ;
      endcase
    end
    // step pulses only count inside an open step frame
    if (!cs_ni && step_valid_i && st_q == ST_STEP) begin
      wcr_op_o   = WOP_STEP;
      wcr_mask_o = one_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= ST_ID;
      opc_q           <= OPC_NOP;
      wsel_q          <= 1'b0;
      ridx_q          <= '0;
      cs_q            <= 1'b1;
      rd_valid_q      <= 1'b0;
      rd_data_q       <= '0;
      pend_q          <= 1'b0;
      pend_mask_q     <= '0;
      pend_idx_q      <= '0;
      pend_from_wcr_q <= 1'b0;
      pend_val_q      <= '0;
    end else begin
      cs_q       <= cs_ni;
      st_q       <= cs_ni ? ST_ID : st_d;
      rd_valid_q <= rd_go;
      if (byte_ok && st_q == ST_INSTR) begin
        opc_q  <= opc_in;
        wsel_q <= byte_i[0];
        ridx_q <= byte_i[3:2];
      end
      if (rd_go)
        rd_data_q <= (opc_in == OPC_STATUS) ? BYTE_W'(wip_i) : BYTE_W'(rd_val_i);
      if (cs_ni) pend_q <= 1'b0;
      else if (pend_set) begin
        pend_q          <= 1'b1;
        pend_mask_q     <= pend_mask_d;
        pend_idx_q      <= pend_idx_d;
        pend_from_wcr_q <= pend_from_wcr_d;
        pend_val_q      <= byte_i[TAP_BITS-1:0];
      end
    end
  end

  assign rd_dr_o       = (opc_in == OPC_RD_DR);
  assign rd_wiper_o    = byte_i[0];
  assign rd_idx_o      = byte_i[3:2];
  assign rd_valid_o    = rd_valid_q;
  assign rd_data_o     = rd_data_q;
  assign step_up_o     = step_up_i;
  assign dr_we_o       = cs_ni && !cs_q && pend_q && wp_ni && !wip_i;
  assign dr_mask_o     = pend_mask_q;
  assign dr_idx_o      = pend_idx_q;
  assign dr_from_wcr_o = pend_from_wcr_q;
  assign dr_val_o      = pend_val_q;

  p_rd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_q |=> !rd_valid_q);
  p_desel_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (st_q == ST_ID));
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import wiper_ctrl_pkg::*;
#(
  parameter int TAP_BITS     = 6,
  parameter int WRITE_CYCLES = 1000,
  localparam int TAPS        = 1 << TAP_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                byte_valid_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                step_valid_i,
  input  logic                step_up_i,
  input  logic                wp_ni,
  input  logic [1:0]          addr_i,
  output logic                rd_valid_o,
  output logic [BYTE_W-1:0]   rd_data_o,
  output logic                wip_o,
  output logic [TAP_BITS-1:0] wcr0_o,
  output logic [TAP_BITS-1:0] wcr1_o,
  output logic [TAPS-1:0]     sel0_o,
  output logic [TAPS-1:0]     sel1_o
);
  wcr_op_e                              wcr_op;
  logic [NUM_WIPERS-1:0]                wcr_mask, dr_mask;
  logic [DR_IDX_BITS-1:0]               wcr_idx, dr_idx, rd_idx;
  logic [TAP_BITS-1:0]                  wcr_val, dr_val, rd_val;
  logic                                 step_up, dr_we, dr_from_wcr, rd_dr, rd_wiper;
  logic [NUM_WIPERS-1:0][TAP_BITS-1:0]  wcr;
  logic [NUM_WIPERS-1:0][TAPS-1:0]      sel;

  wcmd_decoder #(.TAP_BITS(TAP_BITS)) u_dec (
    .clk_i, .rst_ni, .cs_ni, .byte_valid_i, .byte_i, .step_valid_i, .step_up_i,
    .wp_ni, .addr_i, .wip_i(wip_o), .rd_val_i(rd_val),
    .rd_dr_o(rd_dr), .rd_wiper_o(rd_wiper), .rd_idx_o(rd_idx),
    .rd_valid_o, .rd_data_o,
    .wcr_op_o(wcr_op), .wcr_mask_o(wcr_mask), .wcr_idx_o(wcr_idx), .wcr_val_o(wcr_val),
    .step_up_o(step_up),
    .dr_we_o(dr_we), .dr_mask_o(dr_mask), .dr_idx_o(dr_idx),
    .dr_from_wcr_o(dr_from_wcr), .dr_val_o(dr_val)
  );

  wcmd_regbank #(.TAP_BITS(TAP_BITS)) u_regs (
    .clk_i, .rst_ni,
    .wcr_op_i(wcr_op), .wcr_mask_i(wcr_mask), .wcr_idx_i(wcr_idx), .wcr_val_i(wcr_val),
    .step_up_i(step_up),
    .dr_we_i(dr_we), .dr_mask_i(dr_mask), .dr_idx_i(dr_idx),
    .dr_from_wcr_i(dr_from_wcr), .dr_val_i(dr_val),
    .rd_dr_i(rd_dr), .rd_wiper_i(rd_wiper), .rd_idx_i(rd_idx), .rd_val_o(rd_val),
    .wcr_o(wcr)
  );

  wcmd_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_wtimer (
    .clk_i, .rst_ni, .start_i(dr_we), .busy_o(wip_o)
  );

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_sel
    wcmd_tapsel #(.TAP_BITS(TAP_BITS)) u_sel (.code_i(wcr[w]), .sel_o(sel[w]));
  end

  assign wcr0_o = wcr[0];
  assign wcr1_o = wcr[1];
  assign sel0_o = sel[0];
  assign sel1_o = sel[1];

  p_wip_needs_wp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(wp_ni));
  p_wip_from_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(cs_ni));
endmodule

// File: tb/dual_wiper_ctrl_tb_top.sv
module dual_wiper_ctrl_tb_top;
  localparam int WC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        step_valid = 1'b0;
  logic        step_up = 1'b0;
  logic        wp_n = 1'b1;
  logic [1:0]  addr = 2'b10;
  logic        rd_valid_o, wip_o;
  logic [7:0]  rd_data_o;
  logic [5:0]  wcr0_o, wcr1_o;
  logic [63:0] sel0_o, sel1_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit got_rd;
  logic [7:0] rd_cap;

  always #5 clk = ~clk;

  dual_wiper_ctrl #(.TAP_BITS(6), .WRITE_CYCLES(WC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .byte_valid_i(byte_valid), .byte_i(byte_d),
    .step_valid_i(step_valid), .step_up_i(step_up), .wp_ni(wp_n), .addr_i(addr),
    .rd_valid_o, .rd_data_o, .wip_o, .wcr0_o, .wcr1_o, .sel0_o, .sel1_o
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] n;
    logic [7:0] b0, b1, b2;
    logic       chk;
    logic [7:0] rd;
    logic [5:0] w0, w1;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  2'd2, 8'h52, 8'hB0, 8'h00, 1'b1, 8'h00, 6'h00, 6'h00}, // R1 preset cleared
    '{4'd6,  2'd3, 8'h52, 8'hA0, 8'h15, 1'b0, 8'h00, 6'h15, 6'h00}, // R6
    '{4'd6,  2'd3, 8'h52, 8'hA1, 8'hFF, 1'b0, 8'h00, 6'h15, 6'h3F}, // R6 top bits dropped
    '{4'd7,  2'd3, 8'h52, 8'h90, 8'h00, 1'b1, 8'h15, 6'h15, 6'h3F}, // R7
    '{4'd7,  2'd3, 8'h52, 8'h91, 8'h00, 1'b1, 8'h3F, 6'h15, 6'h3F}, // R7
    '{4'd9,  2'd2, 8'h52, 8'hE8, 8'h00, 1'b0, 8'h00, 6'h15, 6'h3F}, // R9 save
    '{4'd9,  2'd3, 8'h52, 8'hCD, 8'h2A, 1'b0, 8'h00, 6'h15, 6'h3F}, // R9 write preset
    '{4'd9,  2'd3, 8'h52, 8'hB8, 8'h00, 1'b1, 8'h15, 6'h15, 6'h3F}, // R9 read back save
    '{4'd9,  2'd3, 8'h52, 8'hBD, 8'h00, 1'b1, 8'h2A, 6'h15, 6'h3F}, // R9 read back write
    '{4'd6,  2'd3, 8'h52, 8'hA0, 8'h01, 1'b0, 8'h00, 6'h01, 6'h3F}, // R6
    '{4'd5,  2'd2, 8'h52, 8'hDD, 8'h00, 1'b0, 8'h00, 6'h01, 6'h2A}, // R5 single load
    '{4'd9,  2'd2, 8'h52, 8'h14, 8'h00, 1'b0, 8'h00, 6'h01, 6'h2A}, // R9 global save
    '{4'd6,  2'd3, 8'h52, 8'hA0, 8'h00, 1'b0, 8'h00, 6'h00, 6'h2A}, // R6
    '{4'd6,  2'd3, 8'h52, 8'hA1, 8'h00, 1'b0, 8'h00, 6'h00, 6'h00}, // R6
    '{4'd5,  2'd2, 8'h52, 8'h84, 8'h00, 1'b0, 8'h00, 6'h01, 6'h2A}, // R5 global load
    '{4'd7,  2'd3, 8'h52, 8'hB5, 8'h00, 1'b1, 8'h2A, 6'h01, 6'h2A}, // R7
    '{4'd2,  2'd3, 8'h51, 8'hA0, 8'h33, 1'b0, 8'h00, 6'h01, 6'h2A}, // R2 address mismatch
    '{4'd2,  2'd3, 8'h72, 8'hA0, 8'h33, 1'b0, 8'h00, 6'h01, 6'h2A}, // R2 type mismatch
    '{4'd3,  2'd3, 8'h52, 8'hA2, 8'h33, 1'b0, 8'h00, 6'h01, 6'h2A}, // R3 reserved bit set
    '{4'd3,  2'd3, 8'h52, 8'h30, 8'h33, 1'b0, 8'h00, 6'h01, 6'h2A}, // R3 unused opcode
    '{4'd8,  2'd3, 8'h52, 8'h50, 8'h00, 1'b1, 8'h00, 6'h01, 6'h2A}  // R8 idle status
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    got_rd = 1'b0;
  endtask

  task automatic cs_high();
    @(negedge clk) cs_n = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_d = b;
    @(negedge clk);
    byte_valid = 1'b0;
    if (rd_valid_o) begin
      got_rd = 1'b1;
      rd_cap = rd_data_o;
    end
  endtask

  task automatic pulse_step(input logic up);
    @(negedge clk);
    step_valid = 1'b1;
    step_up = up;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic read_frame(input logic [7:0] instr);
    cs_low();
    send_byte(8'h52);
    send_byte(instr);
    send_byte(8'h00);
    cs_high();
  endtask

  task automatic write3(input logic [7:0] instr, input logic [7:0] data);
    cs_low();
    send_byte(8'h52);
    send_byte(instr);
    send_byte(data);
    cs_high();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    wait_n(3);
    // R1 reset state
    check("R1 wcr0", 64'(wcr0_o), 64'h0);
    check("R1 wcr1", 64'(wcr1_o), 64'h0);
    check("R1 sel0", sel0_o, 64'h1);
    check("R1 wip", 64'(wip_o), 64'h0);
    check("R1 rd_valid", 64'(rd_valid_o), 64'h0);
    rst_n = 1'b1;
    wait_n(2);

    foreach (VECS[v]) begin
      cs_low();
      send_byte(VECS[v].b0);
      send_byte(VECS[v].b1);
      if (VECS[v].n == 2'd3) send_byte(VECS[v].b2);
      cs_high();
      wait_n(WC + 4);
      check($sformatf("R%0d vec%0d wcr0", VECS[v].req, v), 64'(wcr0_o), 64'(VECS[v].w0));
      check($sformatf("R%0d vec%0d wcr1", VECS[v].req, v), 64'(wcr1_o), 64'(VECS[v].w1));
      check($sformatf("R4 vec%0d sel0", v), sel0_o, 64'd1 << VECS[v].w0);
      check($sformatf("R4 vec%0d sel1", v), sel1_o, 64'd1 << VECS[v].w1);
      if (VECS[v].chk) begin
        check($sformatf("R%0d vec%0d rd_seen", VECS[v].req, v), 64'(got_rd), 64'h1);
        check($sformatf("R%0d vec%0d rd_data", VECS[v].req, v), 64'(rd_cap), 64'(VECS[v].rd));
      end
    end

    // R9 busy window length
    write3(8'hA0, 8'h07);
    wait_n(4);
    write3(8'hC0, 8'h11);
    hi = 0;
    for (int k = 0; k < 3 * WC; k++) begin
      @(negedge clk);
      if (wip_o) hi++;
      else break;
    end
    check("R9 wip length", 64'(hi), 64'(WC));

    // R8 status inside window, R11 save refused inside window
    write3(8'hC0, 8'h22);
    cs_low();
    send_byte(8'h52);
    send_byte(8'h50);
    cs_high();
    check("R8 status busy", 64'(rd_cap), 64'h01);
    cs_low();
    send_byte(8'h52);
    send_byte(8'hE0);
    cs_high();
    wait_n(WC + 4);
    read_frame(8'hB0);
    check("R11 preset kept", 64'(rd_cap), 64'h22);
    check("R11 wip idle", 64'(wip_o), 64'h0);

    // R10 write protect
    wp_n = 1'b0;
    write3(8'hC4, 8'h3C);
    wait_n(1);
    check("R10 wip stays low", 64'(wip_o), 64'h0);
    wait_n(WC + 4);
    wp_n = 1'b1;
    read_frame(8'hB4);
    check("R10 preset kept", 64'(rd_cap), 64'h01);

    // R9 frame cut short
    cs_low();
    send_byte(8'h52);
    send_byte(8'hC9);
    cs_high();
    wait_n(1);
    check("R9 short frame wip", 64'(wip_o), 64'h0);
    wait_n(2);
    read_frame(8'hB9);
    check("R9 short frame preset", 64'(rd_cap), 64'h00);

    // R12 stepping with saturation
    write3(8'hA0, 8'h3D);
    cs_low();
    send_byte(8'h52);
    send_byte(8'h20);
    for (int i = 0; i < 4; i++) pulse_step(1'b1);
    check("R12 up saturate", 64'(wcr0_o), 64'h3F);
    send_byte(8'hA0);
    check("R12 byte ignored", 64'(wcr0_o), 64'h3F);
    pulse_step(1'b0);
    pulse_step(1'b0);
    check("R12 down", 64'(wcr0_o), 64'h3D);
    cs_high();
    pulse_step(1'b1);
    check("R12 step outside mode", 64'(wcr0_o), 64'h3D);
    write3(8'hA1, 8'h01);
    cs_low();
    send_byte(8'h52);
    send_byte(8'h21);
    for (int i = 0; i < 3; i++) pulse_step(1'b0);
    check("R12 down saturate", 64'(wcr1_o), 64'h00);
    check("R4 sel1 at zero", sel1_o, 64'h1);
    check("R12 other wiper", 64'(wcr0_o), 64'h3D);
    cs_high();

    // R13 deselected bytes and trailing bytes
    send_byte(8'h52);
    send_byte(8'hA0);
    send_byte(8'h33);
    check("R13 deselected", 64'(wcr0_o), 64'h3D);
    cs_low();
    send_byte(8'h52);
    send_byte(8'hA0);
    send_byte(8'h05);
    send_byte(8'hA0);
    send_byte(8'h2F);
    cs_high();
    wait_n(2);
    check("R13 trailing bytes", 64'(wcr0_o), 64'h05);
    check("R4 sel0", sel0_o, 64'd1 << 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule